// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block is a register-programmed host controller for a serial flash device. Software fills an eight-entry table of command opcodes, gives each entry a two-bit type, loads two prefix opcodes, a 24-bit flash address and up to 64 bytes of payload. It then writes a control word that names a table entry and sets the go bit. The sequencer builds the serial frame from these registers. The frame is the opcode, then the address when the entry's type carries one, then the payload when the data flag is set. The frame goes out on chip select, serial clock and MOSI in SPI mode 0. In a read, the bytes that arrive on MISO are captured into the payload buffer.

An atomic request first sends the selected prefix opcode in a frame of its own, for example a write-enable. The command frame follows with no other cycle in between. Progress and faults show in a status register with write-one-to-clear flags. A configuration lock freezes the command table, the types and the prefixes until the next reset.

Top module: `spi_flash_seq`

## Requirements
- R1: After reset, status reads 0, the control register reads 0, chip select (`spiCsN`) is high and `spiSclk` is low.
- R2: Register word addresses are as follows:
  - 0: control.
  - 1: status.
  - 2: prefixes, with prefix 0 in bits 7:0 and prefix 1 in bits 15:8.
  - 3: entry types, with entry i in bits 2i+1:2i.
  - 4 to 7: the command table, two entries per word, the even entry in the low byte.
  - 8: address bits 15:0.
  - 9: address bits 23:16 in the low byte.
  - 32 to 63: the payload buffer, word k holding byte 2k low and byte 2k+1 high.
  - All of them read back what was written.
- R3: The control word layout is as follows:
  - bit 0: go.
  - bit 2: atomic.
  - bit 3: prefix select.
  - bits 6:4: table index.
  - bits 13:8: byte count minus one.
  - bit 14: data flag.
  - The go bit reads back as 0.
- R4: The serial interface runs in SPI mode 0. The clock idles low while chip select is high. MOSI changes only while the clock is low. MISO is sampled at the rising edge. Bytes go most significant bit first.
- R5: A command frame carries the table opcode first. For types 2 and 3, the 24-bit address follows, most significant byte first. Payload bytes follow only when the data flag is set. The type codes are: 0 read without address, 1 write without address, 2 read with address, 3 write with address.
- R6: A write type (1 or 3) sends payload bytes from buffer byte 0 upward. A read type (0 or 2) sends zero bytes and stores each received payload byte into the buffer from byte 0 upward.
- R7: Status bit 0 (busy) is high from the accepted go until the frame ends. Bit 1 (done) is set when a cycle completes and is cleared by writing 1 to it.
- R8: A go request is refused when a cycle is running or the selected table opcode is 0. A refused go sets status bit 2 (blocked) and produces no frame. Bit 2 clears on a write of 1. A control write during a cycle leaves the control register unchanged.
- R9: Writing 1 to status bit 3 sets the lock. No write clears it. While it is set, writes to the prefix, type and table registers leave them unchanged.
- R10: With the atomic bit set, the selected prefix opcode is sent as a one-byte frame. Chip select then stays high for at least one serial clock period, and the command frame follows.
- R11: The serial clock period is 2*HALF_DIV system clocks. The payload length is the count field plus one, so 64 bytes is the longest transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 6 | Register word address for read and write |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Read data for `regAddr` (combinational) |
| spiCsN | output | 1 | Flash chip select, active low |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with HALF_DIV = 2, so each serial bit takes four system clocks. This keeps a full 68-byte frame (opcode, address and 64 payload bytes) to a few thousand cycles. Many random cycles, the 64-byte limit, the atomic prefix gap and a go that collides with a running frame therefore all fit in one short run. A serial flash model in the bench returns a position-dependent byte pattern, which makes every captured read byte traceable to its place in the frame.

// File: rtl/spi_seq_pkg.sv
`timescale 1ns/1ps
package spi_seq_pkg;
  localparam int BUF_BYTES = 64;
  localparam int MENU_N    = 8;
  localparam int IDX_W     = $clog2(BUF_BYTES + 4 + 1);

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic             load;        // load shift register with byte loadIdx
    logic             capture;     // sample MISO at rising edge
    logic             shift;       // shift at falling edge
    logic             store;       // byte curIdx complete
    logic             prefixFrame; // frame being built is the prefix frame
    logic [IDX_W-1:0] loadIdx;
    logic [IDX_W-1:0] curIdx;
  } seqStrobe_t;
endpackage

// File: rtl/spi_seq_control.sv
`timescale 1ns/1ps
module spi_seq_control
  import spi_seq_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             atomicReq,
  input  logic [IDX_W-1:0] frameLast,
  output seqStrobe_t       stb,
  output logic             busy,
  output logic             finish,
  output logic             csN,
  output logic             sclk
);
  localparam int CNT_W = $clog2(2 * HALF_DIV + 1);
  localparam logic [CNT_W-1:0] HALF_END = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] GAP_END  = CNT_W'(2 * HALF_DIV - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} seqState_t;

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bitIdx;
  logic [IDX_W-1:0] byteIdx;
  logic             inPrefix;
  logic             tick;
  logic             lastByte;

  assign tick     = (cnt == HALF_END);
  assign lastByte = inPrefix ? (byteIdx == '0) : (byteIdx == frameLast);

  always_comb begin
    stb             = '0;
    stb.prefixFrame = inPrefix;
    stb.curIdx      = byteIdx;
    stb.loadIdx     = byteIdx + 1'b1;
    finish          = 1'b0;
    case (state)
      S_IDLE: if (startPulse) begin
        stb.load        = 1'b1;
        stb.loadIdx     = '0;
        stb.prefixFrame = atomicReq;
      end
      S_SHIFT: if (tick) begin
        if (!sclk) stb.capture = 1'b1;
        else begin
          stb.shift = 1'b1;
          if (bitIdx == 3'd7) begin
            stb.store = 1'b1;
            if (lastByte) finish = !inPrefix;
            else          stb.load = 1'b1;
          end
        end
      end
      S_GAP: if (cnt == GAP_END) begin
        stb.load        = 1'b1;
        stb.loadIdx     = '0;
        stb.prefixFrame = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      byteIdx  <= '0;
      inPrefix <= 1'b0;
      busy     <= 1'b0;
      csN      <= 1'b1;
      sclk     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (startPulse) begin
          state    <= S_SHIFT;
          cnt      <= '0;
          bitIdx   <= '0;
          byteIdx  <= '0;
          inPrefix <= atomicReq;
          busy     <= 1'b1;
          csN      <= 1'b0;
          sclk     <= 1'b0;
        end
        S_SHIFT: begin
          cnt <= tick ? '0 : cnt + 1'b1;
          if (tick) begin
            if (!sclk) sclk <= 1'b1;
            else begin
              sclk <= 1'b0;
              if (bitIdx == 3'd7) begin
                bitIdx <= '0;
                if (lastByte) begin
                  csN <= 1'b1;
                  if (inPrefix) state <= S_GAP;
                  else begin
                    state <= S_IDLE;
                    busy  <= 1'b0;
                  end
                end else byteIdx <= byteIdx + 1'b1;
              end else bitIdx <= bitIdx + 1'b1;
            end
          end
        end
        S_GAP: begin
          cnt <= cnt + 1'b1;
          if (cnt == GAP_END) begin
            cnt      <= '0;
            state    <= S_SHIFT;
            csN      <= 1'b0;
            inPrefix <= 1'b0;
            byteIdx  <= '0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_seq_datapath.sv
`timescale 1ns/1ps
module spi_seq_datapath
  import spi_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [5:0]       regAddr,
  input  logic [15:0]      regWdata,
  output logic [15:0]      regRdata,
  input  seqStrobe_t       stb,
  input  logic             seqBusy,
  input  logic             seqFinish,
  input  logic             csN,
  input  logic             spiMiso,
  output logic             spiMosi,
  output logic             startPulse,
  output logic             atomicQ,
  output logic [IDX_W-1:0] frameLast,
  output logic             doneQ,
  output logic             blockedQ,
  output logic             lockQ
);
  logic [7:0]  menu [MENU_N];
  logic [7:0]  dataBuf [BUF_BYTES];
  logic [15:0] prefixReg, typeReg, ctrlReg;
  logic [23:0] addrReg;
  logic [7:0]  shReg, txByte, rxByte;
  logic        rxBit;

  logic busyAny, wrCtrl, goReq, goOk, stWr, menuWr, bufWr, storeEn;
  logic [2:0] opSel;
  logic [1:0] typeCode;
  logic [IDX_W-1:0] hdrLen, dIdx, sIdx;

  assign busyAny  = seqBusy | startPulse;
  assign opSel    = ctrlReg[6:4];
  assign atomicQ  = ctrlReg[2];
  assign typeCode = typeReg[2*opSel +: 2];
  assign hdrLen   = typeCode[1] ? IDX_W'(4) : IDX_W'(1);
  assign frameLast = (typeCode[1] ? IDX_W'(3) : '0)
                   + (ctrlReg[14] ? IDX_W'(ctrlReg[13:8]) + 1'b1 : '0);

  assign wrCtrl = regWr && (regAddr == 6'd0);
  assign goReq  = wrCtrl && regWdata[0];
  assign goOk   = goReq && !busyAny && (menu[regWdata[6:4]] != 8'h00);
  assign stWr   = regWr && (regAddr == 6'd1);
  assign menuWr = regWr && (regAddr[5:2] == 4'b0001) && !lockQ;
  assign bufWr  = regWr && regAddr[5];

  assign dIdx    = stb.loadIdx - hdrLen;
  assign sIdx    = stb.curIdx - hdrLen;
  assign rxByte  = {shReg[6:0], rxBit};
  assign storeEn = stb.store && !stb.prefixFrame && !typeCode[0]
                && (stb.curIdx >= hdrLen);
  assign spiMosi = !csN && shReg[7];

  always_comb begin
    if (stb.prefixFrame)                         txByte = prefixReg[8*ctrlReg[3] +: 8];
    else if (stb.loadIdx == '0)                  txByte = menu[opSel];
    else if (typeCode[1] && stb.loadIdx == IDX_W'(1)) txByte = addrReg[23:16];
    else if (typeCode[1] && stb.loadIdx == IDX_W'(2)) txByte = addrReg[15:8];
    else if (typeCode[1] && stb.loadIdx == IDX_W'(3)) txByte = addrReg[7:0];
    else if (typeCode[0])                        txByte = dataBuf[dIdx[5:0]];
    else                                         txByte = 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MENU_N; i++)    menu[i]    <= '0;
      for (int i = 0; i < BUF_BYTES; i++) dataBuf[i] <= '0;
      prefixReg  <= '0;
      typeReg    <= '0;
      ctrlReg    <= '0;
      addrReg    <= '0;
      shReg      <= '0;
      rxBit      <= 1'b0;
      startPulse <= 1'b0;
      doneQ      <= 1'b0;
      blockedQ   <= 1'b0;
      lockQ      <= 1'b0;
    end else begin
      startPulse <= goOk;
      if (wrCtrl && !busyAny) ctrlReg <= {regWdata[15:1], 1'b0};
      if (!lockQ && regWr && regAddr == 6'd2) prefixReg <= regWdata;
      if (!lockQ && regWr && regAddr == 6'd3) typeReg   <= regWdata;
      if (menuWr) begin
        menu[{regAddr[1:0], 1'b0}] <= regWdata[7:0];
        menu[{regAddr[1:0], 1'b1}] <= regWdata[15:8];
      end
      if (regWr && regAddr == 6'd8) addrReg[15:0]  <= regWdata;
      if (regWr && regAddr == 6'd9) addrReg[23:16] <= regWdata[7:0];
      if (storeEn) dataBuf[sIdx[5:0]] <= rxByte;
      else if (bufWr) begin
        dataBuf[{regAddr[4:0], 1'b0}] <= regWdata[7:0];
        dataBuf[{regAddr[4:0], 1'b1}] <= regWdata[15:8];
      end
      if (seqFinish)                doneQ <= 1'b1;
      else if (stWr && regWdata[1]) doneQ <= 1'b0;
      if (goReq && !goOk)           blockedQ <= 1'b1;
      else if (stWr && regWdata[2]) blockedQ <= 1'b0;
      if (stWr && regWdata[3])      lockQ <= 1'b1;
      if (stb.capture) rxBit <= spiMiso;
      if (stb.load)       shReg <= txByte;
      else if (stb.shift) shReg <= rxByte;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr[5])
      regRdata = {dataBuf[{regAddr[4:0], 1'b1}], dataBuf[{regAddr[4:0], 1'b0}]};
    else if (regAddr[5:2] == 4'b0001)
      regRdata = {menu[{regAddr[1:0], 1'b1}], menu[{regAddr[1:0], 1'b0}]};
    else case (regAddr)
      6'd0: regRdata = ctrlReg;
      6'd1: regRdata = {12'd0, lockQ, blockedQ, doneQ, busyAny};
      6'd2: regRdata = prefixReg;
      6'd3: regRdata = typeReg;
      6'd8: regRdata = addrReg[15:0];
      6'd9: regRdata = {8'd0, addrReg[23:16]};
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_flash_seq.sv
`timescale 1ns/1ps
module spi_flash_seq
  import spi_seq_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [5:0]  regAddr,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  output logic        spiCsN,
  output logic        spiSclk,
  output logic        spiMosi,
  input  logic        spiMiso
);
  seqStrobe_t       stb;
  logic             seqBusy, seqFinish, startPulse, atomicQ;
  logic             doneQ, blockedQ, lockQ;
  logic [IDX_W-1:0] frameLast;

  spi_seq_control #(.HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .atomicReq(atomicQ),
    .frameLast(frameLast), .stb(stb), .busy(seqBusy), .finish(seqFinish),
    .csN(spiCsN), .sclk(spiSclk)
  );

  spi_seq_datapath u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .stb(stb), .seqBusy(seqBusy),
    .seqFinish(seqFinish), .csN(spiCsN), .spiMiso(spiMiso), .spiMosi(spiMosi),
    .startPulse(startPulse), .atomicQ(atomicQ), .frameLast(frameLast),
    .doneQ(doneQ), .blockedQ(blockedQ), .lockQ(lockQ)
  );
endmodule

// File: rtl/spi_flash_seq_chk.sv
`timescale 1ns/1ps
module spi_flash_seq_chk (
  input logic clk,
  input logic rstN,
  input logic spiCsN,
  input logic spiSclk,
  input logic spiMosi,
  input logic seqBusy,
  input logic startPulse,
  input logic doneQ,
  input logic blockedQ,
  input logic lockQ
);
  assert_clk_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk);

  assert_mosi_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (spiSclk && $past(spiSclk)) |-> $stable(spiMosi));

  assert_busy_frame_R7: assert property (@(posedge clk) disable iff (!rstN)
    !spiCsN |-> seqBusy);

  assert_done_at_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> $fell(seqBusy));

  assert_block_no_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blockedQ) |-> !startPulse);

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);
endmodule

bind spi_flash_seq spi_flash_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSclk(spiSclk),
  .spiMosi(spiMosi), .seqBusy(seqBusy), .startPulse(startPulse),
  .doneQ(doneQ), .blockedQ(blockedQ), .lockQ(lockQ)
);

// File: tb/spi_flash_seq_tb.sv
`timescale 1ns/1ps
module spi_flash_seq_tb;
  localparam int HALF_DIV = 2;
  localparam real TCLK = 5.0;

  logic clk = 1'b0, rstN = 1'b0, regWr = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic spiCsN, spiSclk, spiMosi, spiMiso;

  always #2.5 clk = ~clk;

  spi_flash_seq #(.HALF_DIV(HALF_DIV)) u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .spiCsN(spiCsN),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference state
  logic [7:0]  mMenu [8];
  logic [1:0]  mType [8];
  logic [7:0]  mPre [2];
  logic [23:0] mAddr;
  logic [7:0]  mBuf [64];

  // serial flash model
  logic [7:0] fb [4][72];
  int  fl [4];
  int  nFrames = 0, bitCnt = 0, patKey = 0;
  logic [7:0] sh = '0;
  realtime tCsRise = 0, lastGap = 0, tSclk = 0, sclkPer = 0;

  function automatic logic [7:0] misoPat(int k, int key);
    return 8'(k * 29 + key);
  endfunction
  function automatic logic misoBit(int b, int key);
    logic [7:0] v;
    v = misoPat(b / 8, key);
    return v[7 - (b % 8)];
  endfunction

  assign spiMiso = spiCsN ? 1'b0 : misoBit(bitCnt, patKey);

  always @(posedge spiSclk) begin
    sh = {sh[6:0], spiMosi};
    if (bitCnt % 8 == 7 && nFrames < 4 && bitCnt / 8 < 72) fb[nFrames][bitCnt / 8] = sh;
    bitCnt++;
    if (tSclk > 0) sclkPer = $realtime - tSclk;
    tSclk = $realtime;
  end
  always @(negedge spiCsN) begin
    bitCnt = 0;
    tSclk = 0;
    if (nFrames > 0) lastGap = $realtime - tCsRise;
  end
  always @(posedge spiCsN) begin
    if (rstN) begin
      if (nFrames < 4) fl[nFrames] = bitCnt / 8;
      nFrames++;
      tCsRise = $realtime;
    end
  end

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic regWrite(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitIdle();
    logic [15:0] s;
    int n = 0;
    do begin regRead(6'd1, s); n++; end while (s[0] && n < 20000);
  endtask

  function automatic logic [15:0] typeWord();
    logic [15:0] w = '0;
    for (int i = 0; i < 8; i++) w[2*i +: 2] = mType[i];
    return w;
  endfunction

  task automatic programAll();
    for (int k = 0; k < 4; k++) regWrite(6'(4 + k), {mMenu[2*k+1], mMenu[2*k]});
    regWrite(6'd3, typeWord());
    regWrite(6'd2, {mPre[1], mPre[0]});
    regWrite(6'd8, mAddr[15:0]);
    regWrite(6'd9, {8'd0, mAddr[23:16]});
  endtask

  task automatic loadBuf();
    for (int i = 0; i < 32; i++) begin
      mBuf[2*i]   = 8'($urandom);
      mBuf[2*i+1] = 8'($urandom);
      regWrite(6'(32 + i), {mBuf[2*i+1], mBuf[2*i]});
    end
  endtask

  function automatic logic [15:0] ctrlWord(int op, int pre, bit atom, bit df, int cnt);
    return {1'b0, df, 6'(cnt - 1), 1'b0, 3'(op), 1'(pre), atom, 1'b0, 1'b1};
  endfunction

  // one full cycle with checks of every frame byte and of the read buffer
  task automatic runCycle(int op, int pre, bit atom, bit df, int cnt);
    logic [15:0] s, w;
    int f, hdr, len, bad;
    logic [7:0] e, a;
    bit hasA, wr;
    nFrames = 0;
    patKey = int'($urandom % 256);
    regWrite(6'd0, ctrlWord(op, pre, atom, df, cnt));
    waitIdle();
    check(nFrames == (atom ? 2 : 1), atom ? "R10" : "R5", "frame count", nFrames, atom ? 2 : 1);
    f = 0;
    if (atom) begin
      check(fl[0] == 1 && fb[0][0] == mPre[pre], "R10", "prefix frame", fb[0][0], mPre[pre]);
      check(lastGap >= 2 * HALF_DIV * TCLK, "R10", "cs gap ns", longint'(lastGap), 2 * HALF_DIV * 5);
      f = 1;
    end
    hasA = mType[op][1];
    wr   = mType[op][0];
    hdr  = hasA ? 4 : 1;
    len  = hdr + (df ? cnt : 0);
    check(fl[f] == len, "R5", "frame length", fl[f], len);
    bad = -1; e = 0; a = 0;
    for (int k = 0; k < len && k < 72; k++) begin
      logic [7:0] x;
      if (k == 0)              x = mMenu[op];
      else if (hasA && k == 1) x = mAddr[23:16];
      else if (hasA && k == 2) x = mAddr[15:8];
      else if (hasA && k == 3) x = mAddr[7:0];
      else if (wr)             x = mBuf[k - hdr];
      else                     x = 8'h00;
      if (bad < 0 && fb[f][k] !== x) begin bad = k; e = x; a = fb[f][k]; end
    end
    check(bad < 0, wr ? "R6" : "R5", "mosi byte", a, e);
    if (!wr && df) begin
      bad = -1;
      for (int i = 0; i < cnt; i++) mBuf[i] = misoPat(hdr + i, patKey);
      for (int i = 0; i < (cnt + 1) / 2; i++) begin
        regRead(6'(32 + i), w);
        if (bad < 0 && w[7:0] !== mBuf[2*i]) begin bad = 2*i; e = mBuf[2*i]; a = w[7:0]; end
        if (bad < 0 && 2*i+1 < cnt && w[15:8] !== mBuf[2*i+1]) begin
          bad = 2*i+1; e = mBuf[2*i+1]; a = w[15:8];
        end
      end
      check(bad < 0, "R6", "read buffer byte", a, e);
    end
    regRead(6'd1, s);
    check(s[1] == 1'b1, "R7", "done flag", s[1], 1);
    regWrite(6'd1, 16'h0002);
  endtask

  initial begin
    logic [15:0] s, w;
    void'($urandom(32'h5EED_0042));
    mMenu = '{8'h9F, 8'h01, 8'h03, 8'h02, 8'h0B, 8'h00, 8'hD8, 8'h05};
    mType = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd2, 2'd0, 2'd3, 2'd0};
    mPre  = '{8'h06, 8'h50};
    mAddr = 24'hA5C3_17;
    for (int i = 0; i < 64; i++) mBuf[i] = '0;

    repeat (3) @(negedge clk);
    regRead(6'd1, s);
    check(s == 16'h0000, "R1", "status after reset", s, 0);
    regRead(6'd0, s);
    check(s == 16'h0000, "R1", "control after reset", s, 0);
    check(spiCsN === 1'b1 && spiSclk === 1'b0, "R1", "cs/sclk idle", {spiCsN, spiSclk}, 2'b10);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    programAll();
    regRead(6'd5, w);
    check(w == {mMenu[3], mMenu[2]}, "R2", "menu word readback", w, {mMenu[3], mMenu[2]});
    regRead(6'd3, w);
    check(w == typeWord(), "R2", "type readback", w, typeWord());
    regRead(6'd9, w);
    check(w == {8'd0, mAddr[23:16]}, "R2", "address high readback", w, mAddr[23:16]);
    loadBuf();

    // write with address and data
    runCycle(3, 0, 0, 1, 5);
    check(sclkPer == 2 * HALF_DIV * TCLK, "R11", "sclk period ns", longint'(sclkPer), 2 * HALF_DIV * 5);
    regRead(6'd0, w);
    check(w == ctrlWord(3, 0, 0, 1, 5) - 16'd1, "R3", "control readback go clear", w, ctrlWord(3, 0, 0, 1, 5) - 16'd1);
    regRead(6'd1, s);
    check(s[1] == 1'b0, "R7", "done cleared by write one", s[1], 0);
    // read with address
    runCycle(2, 0, 0, 1, 8);
    // opcode only
    runCycle(0, 0, 0, 0, 1);
    // write without address, one byte
    runCycle(1, 0, 0, 1, 1);
    // atomic prefix 1, write with address 16 bytes
    loadBuf();
    runCycle(6, 1, 1, 1, 16);

    // refused go: zero opcode
    nFrames = 0;
    regWrite(6'd0, ctrlWord(5, 0, 0, 0, 1));
    repeat (40) @(negedge clk);
    regRead(6'd1, s);
    check(s[2] == 1'b1 && nFrames == 0, "R8", "blocked on zero opcode", {s[2], 8'(nFrames)}, 9'h100);
    regWrite(6'd1, 16'h0004);
    regRead(6'd1, s);
    check(s[2] == 1'b0, "R8", "blocked cleared", s[2], 0);

    // refused go while busy, longest transfer
    nFrames = 0;
    patKey = 77;
    regWrite(6'd0, ctrlWord(2, 0, 0, 1, 64));
    regWrite(6'd0, ctrlWord(0, 0, 0, 0, 1));
    regRead(6'd1, s);
    check(s[2] == 1'b1 && s[0] == 1'b1, "R8", "blocked while busy", s[2:0], 3'b101);
    regRead(6'd0, w);
    check(w == ctrlWord(2, 0, 0, 1, 64) - 16'd1, "R8", "control kept while busy", w, ctrlWord(2, 0, 0, 1, 64) - 16'd1);
    waitIdle();
    check(nFrames == 1 && fl[0] == 68, "R11", "64 byte frame length", fl[0], 68);
    regRead(6'd63, w);
    check(w == {misoPat(67, 77), misoPat(66, 77)}, "R11", "last buffer word", w, {misoPat(67, 77), misoPat(66, 77)});
    for (int i = 0; i < 64; i++) mBuf[i] = misoPat(4 + i, 77);
    regWrite(6'd1, 16'h0006);

    // lock
    regWrite(6'd1, 16'h0008);
    regWrite(6'd4, 16'hFFFF);
    regWrite(6'd2, 16'h1234);
    regWrite(6'd3, 16'h0000);
    regRead(6'd4, w);
    check(w == {mMenu[1], mMenu[0]}, "R9", "menu write ignored", w, {mMenu[1], mMenu[0]});
    regRead(6'd2, w);
    check(w == {mPre[1], mPre[0]}, "R9", "prefix write ignored", w, {mPre[1], mPre[0]});
    regRead(6'd3, w);
    check(w == typeWord(), "R9", "type write ignored", w, typeWord());
    regWrite(6'd1, 16'h0000);
    regWrite(6'd1, 16'h0008);
    regRead(6'd1, s);
    check(s[3] == 1'b1, "R9", "lock not clearable", s[3], 1);

    // random cycles with the locked table
    for (int t = 0; t < 40; t++) begin
      int op, r, cnt;
      do op = int'($urandom % 8); while (op == 5);
      r = int'($urandom % 15);
      cnt = (r < 8) ? r + 1 : (r - 6) * 8;
      mAddr = 24'($urandom);
      regWrite(6'd8, mAddr[15:0]);
      regWrite(6'd9, {8'd0, mAddr[23:16]});
      if (mType[op][0] && (t % 4 == 0)) loadBuf();
      runCycle(op, int'($urandom % 2), 1'($urandom), 1'($urandom), cnt);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule